// File: doc/BRIEF.md
# Sixteen-Bit Gated Timer/Counter

This block is a 16-bit up-counter whose value is read and loaded one byte at a time. It advances on one of two sources: an internal tick that fires once every four system clocks, or rising edges on an external input. Each source passes through a hidden prescaler that divides by 1, 2, 4 or 8. Any byte load clears the prescaler. An on control starts and stops counting.

An optional gate lets counts through only while a gate input sits at a chosen level, so the counter can measure how long an external pulse lasts. External edges can take a two-flop resynchronizer path, or a shorter path that only detects the edge and still runs in the same clock domain. A wrap from FFFFh to 0000h sets a sticky overflow flag that software clears. The interrupt output is that flag masked by an enable.

All controls are plain input pins sampled on every clock. Reset is synchronous and active high.

Top module: `gt16_timer`

## Requirements
- R1: Reset sets the count to 0000h, clears the overflow flag and holds the interrupt low.
- R2: With the source select at 0 and the prescaler at divide-by-1, the count rises by exactly one for every four system clocks that counting is on. The synchronize bit has no effect in this mode.
- R3: The 2-bit prescale field selects how many source events make one increment: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R4: With the source select at 1, only rising edges of the external input are counted. A falling edge or a steady level adds nothing.
- R5: With the synchronize bit at 0, a rising edge that appears on the external input between two clock edges changes the count on the third following clock edge.
- R6: With the synchronize bit at 1, such an edge changes the count on the first following clock edge.
- R7: While the on bit is 0, the count holds its value whatever the sources do.
- R8: With gate enable at 1, events are counted only while the gate input equals the gate polarity bit (1 means active high). With gate enable at 0, the gate input is ignored.
- R9: A low-byte or high-byte load replaces that byte on the next clock edge and leaves the other byte unchanged. A load takes priority over an increment in the same cycle.
- R10: A load of either byte clears the prescaler, so a full prescale period of events must follow before the next increment.
- R11: An increment from FFFFh gives 0000h and sets the overflow flag. The clear input resets the flag, but a set in the same cycle wins over the clear.
- R12: The interrupt output is high exactly when the overflow flag and the interrupt enable are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_on | input | 1 | 1 enables counting |
| ctl_src | input | 1 | 0 counts the internal tick, 1 counts external edges |
| ctl_nosync | input | 1 | 1 bypasses the external resynchronizer |
| ctl_gate_en | input | 1 | 1 qualifies counting with the gate input |
| ctl_gate_pol | input | 1 | Active level of the gate input |
| ctl_psel | input | 2 | Prescale select (00=1, 01=2, 10=4, 11=8) |
| ext_in | input | 1 | External count input |
| gate_in | input | 1 | Gate input |
| wr_lo | input | 1 | Load the low byte from wr_data |
| wr_hi | input | 1 | Load the high byte from wr_data |
| wr_data | input | 8 | Byte load data |
| rd_lo | output | 8 | Count, low byte |
| rd_hi | output | 8 | Count, high byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clear the overflow flag |
| ovf_ie | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in the same clock edge. The first pair is the wrap that sets the overflow flag and a software clear of that flag. The bench preloads FFFFh with the flag already set, then raises the external input and the clear on the same cycle in the unsynchronized mode. It expects a count of 0000h and the flag still high, and a later clear on its own must drop the flag. The second pair is a byte load and an increment in the same cycle. The load must win, with no increment added.

// File: rtl/gt16_pkg.sv
package gt16_pkg;
  localparam int BYTE_W     = 8;
  localparam int PSEL_W     = 2;
  localparam int TICK_DIV   = 4;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [PSEL_W-1:0] {
    PS_DIV1 = 2'b00,
    PS_DIV2 = 2'b01,
    PS_DIV4 = 2'b10,
    PS_DIV8 = 2'b11
  } psel_e;
endpackage

// File: rtl/gt16_tick_gen.sv
module gt16_tick_gen #(
  parameter int TICK_DIV   = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  output logic int_tick,
  output logic ext_rise_sync,
  output logic ext_rise_raw
);
  localparam int PH_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICK_DIV - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)                   phase_q <= '0;
    else if (phase_q == PH_LAST) phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end

  assign int_tick = (phase_q == PH_LAST);

  // Stages 0..SYNC_DEPTH-1 form the resynchronizer; the last stage holds the previous value.
  logic [SYNC_DEPTH:0] chain_q;

  generate
    for (genvar s = 0; s <= SYNC_DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= ext_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign ext_rise_sync = chain_q[SYNC_DEPTH-1] & ~chain_q[SYNC_DEPTH];
  assign ext_rise_raw  = ext_in & ~chain_q[0];
endmodule

// File: rtl/gt16_prescaler.sv
module gt16_prescaler #(
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick_in,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick_out
);
  localparam int PC_W = (2 ** PSEL_W) - 1;

  logic [PC_W-1:0] pcnt_q;
  logic [PC_W-1:0] limit;

  always_comb begin
    for (int i = 0; i < PC_W; i++) begin
      limit[i] = (i < int'(psel));
    end
  end

  assign tick_out = tick_in & ~clr & (pcnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)    pcnt_q <= '0;
    else if (tick_out) pcnt_q <= '0;
    else if (tick_in)  pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/gt16_counter.sv
module gt16_counter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ovf_clr,
  output logic [2*BYTE_W-1:0] count,
  output logic              ovf_flag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             any_wr;
  logic             wrap;

  assign any_wr = wr_lo | wr_hi;
  assign wrap   = inc & ~any_wr & (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (any_wr) begin
      if (wr_lo) cnt_q[BYTE_W-1:0]     <= wr_data;
      if (wr_hi) cnt_q[CNT_W-1:BYTE_W] <= wr_data;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (wrap)    flag_q <= 1'b1;
    else if (ovf_clr) flag_q <= 1'b0;
  end

  assign count    = cnt_q;
  assign ovf_flag = flag_q;
endmodule

// File: rtl/gt16_timer.sv
module gt16_timer
  import gt16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_on,
  input  logic              ctl_src,
  input  logic              ctl_nosync,
  input  logic              ctl_gate_en,
  input  logic              ctl_gate_pol,
  input  logic [PSEL_W-1:0] ctl_psel,
  input  logic              ext_in,
  input  logic              gate_in,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_lo,
  output logic [BYTE_W-1:0] rd_hi,
  output logic              ovf_flag,
  input  logic              ovf_clr,
  input  logic              ovf_ie,
  output logic              irq
);
  logic int_tick, rise_sync, rise_raw;
  logic src_evt, gate_ok, qual_evt, inc;
  logic [2*BYTE_W-1:0] count;

  gt16_tick_gen #(.TICK_DIV(TICK_DIV), .SYNC_DEPTH(SYNC_DEPTH)) u_src (
    .clk(clk), .rst(rst), .ext_in(ext_in),
    .int_tick(int_tick), .ext_rise_sync(rise_sync), .ext_rise_raw(rise_raw)
  );

  always_comb begin
    if (!ctl_src)       src_evt = int_tick;
    else if (ctl_nosync) src_evt = rise_raw;
    else                src_evt = rise_sync;
  end

  assign gate_ok  = ~ctl_gate_en | (gate_in == ctl_gate_pol);
  assign qual_evt = ctl_on & gate_ok & src_evt;

  gt16_prescaler #(.PSEL_W(PSEL_W)) u_psc (
    .clk(clk), .rst(rst), .clr(wr_lo | wr_hi),
    .tick_in(qual_evt), .psel(ctl_psel), .tick_out(inc)
  );

  gt16_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(inc),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .ovf_clr(ovf_clr), .count(count), .ovf_flag(ovf_flag)
  );

  assign rd_lo = count[BYTE_W-1:0];
  assign rd_hi = count[2*BYTE_W-1:BYTE_W];
  assign irq   = ovf_flag & ovf_ie;
endmodule

// File: rtl/gt16_checker.sv
module gt16_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_on,
  input logic              ctl_gate_en,
  input logic              ctl_gate_pol,
  input logic              gate_in,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic [BYTE_W-1:0] wr_data,
  input logic [BYTE_W-1:0] rd_lo,
  input logic [BYTE_W-1:0] rd_hi,
  input logic              ovf_flag
);
  logic [2*BYTE_W-1:0] cnt;
  logic                no_wr;
  assign cnt   = {rd_hi, rd_lo};
  assign no_wr = ~wr_lo & ~wr_hi;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !ovf_flag)); // R1

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    no_wr |=> (cnt == $past(cnt) || cnt == (2*BYTE_W)'($past(cnt) + 1'b1))); // R3

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctl_on && no_wr) |=> $stable(cnt)); // R7

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (ctl_gate_en && (gate_in != ctl_gate_pol) && no_wr) |=> $stable(cnt)); // R8

  AST_LOW_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (rd_lo == $past(wr_data))); // R9

  AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> $stable(rd_hi)); // R9

  AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (no_wr && cnt == '1) |=> (cnt != '0 || ovf_flag)); // R11
endmodule

bind gt16_timer gt16_checker #(.BYTE_W(gt16_pkg::BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_on(ctl_on), .ctl_gate_en(ctl_gate_en),
  .ctl_gate_pol(ctl_gate_pol), .gate_in(gate_in), .wr_lo(wr_lo),
  .wr_hi(wr_hi), .wr_data(wr_data), .rd_lo(rd_lo), .rd_hi(rd_hi),
  .ovf_flag(ovf_flag)
);

// File: tb/gt16_timer_tb.sv
module gt16_timer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_on = 0, ctl_src = 0, ctl_nosync = 0, ctl_gate_en = 0, ctl_gate_pol = 1;
  logic [1:0] ctl_psel = 2'b00;
  logic ext_in = 0, gate_in = 0, wr_lo = 0, wr_hi = 0, ovf_clr = 0, ovf_ie = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_lo, rd_hi;
  logic ovf_flag, irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gt16_timer u_dut (
    .clk(clk), .rst(rst), .ctl_on(ctl_on), .ctl_src(ctl_src), .ctl_nosync(ctl_nosync),
    .ctl_gate_en(ctl_gate_en), .ctl_gate_pol(ctl_gate_pol), .ctl_psel(ctl_psel),
    .ext_in(ext_in), .gate_in(gate_in), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
    .ovf_ie(ovf_ie), .irq(irq)
  );

  function automatic logic [15:0] cnt();
    return {rd_hi, rd_lo};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load16(input logic [15:0] v);
    @(negedge clk); wr_lo = 1; wr_data = v[7:0];
    @(negedge clk); wr_lo = 0; wr_hi = 1; wr_data = v[15:8];
    @(negedge clk); wr_hi = 0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_in = 1;
      @(negedge clk); ext_in = 0;
    end
    @(negedge clk);
  endtask

  task automatic ext_mode(input logic nosync, input logic [1:0] ps);
    @(negedge clk); ctl_on = 0; ctl_src = 1; ctl_nosync = nosync; ctl_psel = ps;
    ctl_gate_en = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 count", cnt(), 16'h0000);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_internal();
    @(negedge clk); ctl_src = 0; ctl_psel = 2'b00; ctl_on = 0;
    load16(16'h0000);
    ctl_on = 1; repeat (40) @(negedge clk); ctl_on = 0;
    @(negedge clk);
    chk("R2 div4 tick", cnt(), 16'd10);
    ctl_psel = 2'b01; ctl_nosync = 1;
    load16(16'h0000);
    ctl_on = 1; repeat (80) @(negedge clk); ctl_on = 0;
    @(negedge clk);
    chk("R2 R3 tick with div2, sync bit ignored", cnt(), 16'd10);
  endtask

  task automatic t_prescale();
    ext_mode(1, 2'b00); load16(16'h0000); ctl_on = 1;
    pulse(3);
    chk("R3 div1", cnt(), 16'd3);
    ctl_psel = 2'b01; load16(16'h0000);
    pulse(3);
    chk("R3 div2 partial", cnt(), 16'd1);
    ctl_psel = 2'b10; load16(16'h0000);
    pulse(7);
    chk("R3 div4 seven", cnt(), 16'd1);
    pulse(1);
    chk("R3 div4 eight", cnt(), 16'd2);
  endtask

  task automatic t_clear_psc();
    ext_mode(1, 2'b11); load16(16'h0000); ctl_on = 1;
    pulse(5);
    chk("R10 before load", cnt(), 16'd0);
    @(negedge clk); wr_lo = 1; wr_data = 8'h10;
    @(negedge clk); wr_lo = 0;
    pulse(7);
    chk("R10 seven after load", cnt(), 16'h0010);
    pulse(1);
    chk("R10 eighth after load", cnt(), 16'h0011);
  endtask

  task automatic t_edges();
    ext_mode(1, 2'b00); load16(16'h0000); ctl_on = 1;
    @(negedge clk); ext_in = 1;
    repeat (5) @(negedge clk);
    ext_in = 0;
    repeat (5) @(negedge clk);
    chk("R4 one rise only", cnt(), 16'd1);
  endtask

  task automatic t_latency();
    ext_mode(0, 2'b00); load16(16'h0000); ctl_on = 1;
    @(negedge clk); ext_in = 1;
    @(negedge clk); chk("R5 edge1", cnt(), 16'd0);
    @(negedge clk); chk("R5 edge2", cnt(), 16'd0);
    @(negedge clk); chk("R5 edge3", cnt(), 16'd1);
    ext_in = 0; repeat (4) @(negedge clk);
    ctl_nosync = 1; repeat (2) @(negedge clk);
    ext_in = 1;
    @(negedge clk); chk("R6 edge1", cnt(), 16'd2);
    ext_in = 0; @(negedge clk);
  endtask

  task automatic t_off();
    ext_mode(1, 2'b00); load16(16'h0042);
    pulse(4);
    chk("R7 held while off", cnt(), 16'h0042);
  endtask

  task automatic t_gate();
    ext_mode(1, 2'b00); load16(16'h0000); ctl_on = 1;
    ctl_gate_en = 1; ctl_gate_pol = 1; gate_in = 0;
    pulse(3);
    chk("R8 high gate closed", cnt(), 16'd0);
    gate_in = 1; pulse(3);
    chk("R8 high gate open", cnt(), 16'd3);
    ctl_gate_pol = 0; pulse(2);
    chk("R8 low gate closed", cnt(), 16'd3);
    gate_in = 0; pulse(2);
    chk("R8 low gate open", cnt(), 16'd5);
    ctl_gate_en = 0; gate_in = 1; pulse(2);
    chk("R8 gate ignored", cnt(), 16'd7);
  endtask

  task automatic t_write();
    ext_mode(1, 2'b00); load16(16'h1234); ctl_on = 1;
    chk("R9 both bytes", cnt(), 16'h1234);
    @(negedge clk); ext_in = 1; wr_lo = 1; wr_data = 8'h55;
    @(negedge clk); wr_lo = 0; ext_in = 0;
    chk("R9 load beats increment", cnt(), 16'h1255);
    @(negedge clk); wr_hi = 1; wr_data = 8'hA0;
    @(negedge clk); wr_hi = 0;
    chk("R9 high byte only", cnt(), 16'hA055);
  endtask

  task automatic t_overflow();
    ext_mode(1, 2'b00); load16(16'hFFFF); ctl_on = 1; ovf_ie = 1;
    chk("R11 flag before wrap", ovf_flag, 0);
    pulse(1);
    chk("R11 wrap value", cnt(), 16'h0000);
    chk("R11 flag set", ovf_flag, 1);
    chk("R12 irq enabled", irq, 1);
    ovf_ie = 0; @(negedge clk);
    chk("R12 irq masked", irq, 0);
    load16(16'hFFFF);
    @(negedge clk); ext_in = 1; ovf_clr = 1;
    @(negedge clk); ext_in = 0; ovf_clr = 0;
    chk("R11 set beats clear value", cnt(), 16'h0000);
    chk("R11 set beats clear flag", ovf_flag, 1);
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    chk("R11 clear alone", ovf_flag, 0);
    ovf_ie = 1; @(negedge clk);
    chk("R12 no flag no irq", irq, 0);
    ovf_ie = 0;
  endtask

  task automatic t_reset_again();
    ext_mode(1, 2'b00); load16(16'hABCD);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 reset after use", cnt(), 16'h0000);
  endtask

  initial begin
    t_reset();
    t_internal();
    t_prescale();
    t_clear_psc();
    t_edges();
    t_latency();
    t_off();
    t_gate();
    t_write();
    t_overflow();
    t_reset_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule